// File: doc/BRIEF.md
# Pixel FIFO Fetch Controller

This block governs a single pixel FIFO that sits between a memory read initiator and a display video pipeline. The memory side writes words through a simple write port, and the pipeline drains them through a valid/ready port. A fetch-request output tells the memory side when to fetch. Two programmable watermarks give this request hysteresis: it turns on when the FIFO runs low and stays on until the FIFO is nearly full.

At the start of each frame the output side is held back. It waits until a preload level of pixels has built up, so the first line does not starve. The preload level comes either from a 12-bit preload register or from the high watermark. A write attempt into a full FIFO releases this hold early.

The FIFO is emptied when the vertical front porch begins. It is also emptied whenever the display controller is switched on or off. In self-refresh mode the front-porch event does not empty the FIFO. Instead it rewinds the read side, so the pixels stored since the last flush are shown again in the next frame. In that mode no new fetches are requested.

Top module: `pfc_top`

## Requirements
- R1: `fetch_req` rises on the clock edge after occupancy is at or below `cfg_low`. It then holds high while occupancy lies between the two watermarks, and it falls on the clock edge after occupancy reaches `cfg_high` or more.
- R2: `fetch_req` is held low on the edge after `ctl_enable` is 0 or `cfg_self_refresh` is 1.
- R3: After a flush, `pix_valid` stays low until occupancy has reached the preload level, and it is high from the following cycle. With `cfg_preload_sel` = 0 the level is the 12-bit `cfg_preload`; with `cfg_preload_sel` = 1 the level is `cfg_high`.
- R4: A write attempt (`wr_en` = 1) while the FIFO is full is dropped. It opens the output gate on the next edge, even when the preload level has not been reached.
- R5: A `vfp_start` pulse with `cfg_self_refresh` = 0 flushes the FIFO in one cycle. Occupancy becomes zero, the preload gate closes again, and any write offered in that cycle is discarded.
- R6: Any change of `ctl_enable` flushes the FIFO in the same way as R5.
- R7: A `vfp_start` pulse with `cfg_self_refresh` = 1 does not discard data. It rewinds the read side and keeps the gate open, so every word written since the last flush is delivered again, in write order.
- R8: `cfg_err` is 1 when `cfg_low` >= `cfg_high`, or when `cfg_high` exceeds the depth. It is also 1 when `cfg_preload_sel` = 0 and `cfg_preload` lies outside the range `cfg_low`..`cfg_high`.
- R9: `underflow` is a sticky flag. It is set when the controller is enabled, `vid_active` = 1, the gate is open, `pix_ready` = 1 and the FIFO is empty. A one-cycle `uf_clr` clears it. It is not set while `vid_active` = 0.
- R10: `wr_ready` is 1 exactly when the FIFO is not full, and pixels leave in the order they were accepted.
- R11: After reset, `fetch_req`, `pix_valid` and `underflow` are 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Display controller enable; any change flushes the FIFO |
| vfp_start | input | 1 | One-cycle strobe at the start of vertical front porch |
| vid_active | input | 1 | High during active video |
| cfg_low | input | CNT_W | Low watermark |
| cfg_high | input | CNT_W | High watermark |
| cfg_preload | input | 12 | Programmed preload level |
| cfg_preload_sel | input | 1 | 0: use cfg_preload, 1: use cfg_high as the preload level |
| cfg_self_refresh | input | 1 | Keep and replay the FIFO contents across frames |
| wr_en | input | 1 | Write strobe from the memory side |
| wr_data | input | DATA_W | Write data |
| wr_ready | output | 1 | FIFO not full |
| fetch_req | output | 1 | Request to fetch more data from memory |
| pix_valid | output | 1 | Pixel available to the pipeline |
| pix_ready | input | 1 | Pipeline takes a pixel |
| pix_data | output | DATA_W | Pixel data |
| uf_clr | input | 1 | Write-one-to-clear strobe for underflow |
| underflow | output | 1 | Sticky underflow flag |
| cfg_err | output | 1 | Watermark or preload setting inconsistent |

## Verification
The watermark logic is tested in three ways:
- a monotonic fill followed by a drain, which separates the rising threshold from the falling one;
- a partial drain that stops between the watermarks, which shows whether hysteresis holds the request;
- a drain past the low mark, which shows the request coming back.

Preload gating is tested with both level sources. A fill that stops one word short of the level tells a greater-or-equal comparison from an off-by-one. A preload level beyond the depth, followed by an extra write into the full FIFO, shows the overflow release on its own.

Flush and replay are told apart by a front-porch pulse with self-refresh off and with it on. A word offered in the flush cycle must not appear, and the scoreboard must see a replayed frame repeat in exact order.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   localparam int PRELOAD_W = 12;

   // frame / control event decoded each cycle
   typedef enum logic [1:0] {
      EVT_NONE   = 2'd0,
      EVT_FRAME  = 2'd1,
      EVT_CTRL   = 2'd2,
      EVT_REPLAY = 2'd3
   } frame_evt_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pfc_store.sv
module pfc_store #(
   parameter int DATA_W = 24,
   parameter int DEPTH  = 256,
   parameter int ADDR_W = $clog2(DEPTH),
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              flush,
   input  logic              replay,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] wr_ptr;
   logic [ADDR_W-1:0] rd_ptr;
   logic [CNT_W-1:0]  fill;

   assign full  = (count == DEPTH_C);
   assign empty = (count == '0);
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
      end else if (push) begin
         wr_ptr <= wr_ptr + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
      end else if (flush || replay) begin
         rd_ptr <= '0;
      end else if (pop) begin
         rd_ptr <= rd_ptr + 1'b1;
      end
   end

   // words written since the last flush, saturating at the depth
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
      end else if (flush) begin
         fill <= '0;
      end else if (push && (fill != DEPTH_C)) begin
         fill <= fill + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (flush) begin
         count <= '0;
      end else if (replay) begin
         count <= fill;
      end else begin
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/pfc_watermark.sv
module pfc_watermark #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             allow,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] low_mark,
   input  logic [CNT_W-1:0] high_mark,
   output logic             req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
      end else if (!allow) begin
         req <= 1'b0;
      end else if (count <= low_mark) begin
         req <= 1'b1;
      end else if (count >= high_mark) begin
         req <= 1'b0;
      end
   end

endmodule

// File: rtl/pfc_gate.sv
module pfc_gate #(
   parameter int CMP_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             replay,
   input  logic             ovf_try,
   input  logic [CMP_W-1:0] occ,
   input  logic [CMP_W-1:0] level,
   input  logic             enabled,
   input  logic             vid_active,
   input  logic             pix_ready,
   input  logic             empty,
   input  logic             uf_clr,
   output logic             gate_open,
   output logic             underflow
);

   logic uf_set;

   assign uf_set = enabled && vid_active && gate_open && pix_ready && empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_open <= 1'b0;
      end else if (flush) begin
         gate_open <= 1'b0;
      end else if (replay) begin
         gate_open <= 1'b1;
      end else if (!gate_open && ((occ >= level) || ovf_try)) begin
         gate_open <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         underflow <= 1'b0;
      end else if (uf_set) begin
         underflow <= 1'b1;
      end else if (uf_clr) begin
         underflow <= 1'b0;
      end
   end

endmodule

// File: rtl/pfc_top.sv
module pfc_top
   import pfc_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_enable,
   input  logic                 vfp_start,
   input  logic                 vid_active,
   input  logic [CNT_W-1:0]     cfg_low,
   input  logic [CNT_W-1:0]     cfg_high,
   input  logic [PRELOAD_W-1:0] cfg_preload,
   input  logic                 cfg_preload_sel,
   input  logic                 cfg_self_refresh,
   input  logic                 wr_en,
   input  logic [DATA_W-1:0]    wr_data,
   output logic                 wr_ready,
   output logic                 fetch_req,
   output logic                 pix_valid,
   input  logic                 pix_ready,
   output logic [DATA_W-1:0]    pix_data,
   input  logic                 uf_clr,
   output logic                 underflow,
   output logic                 cfg_err
);

   localparam int CMP_W = max_of(PRELOAD_W, CNT_W);
   localparam logic [CMP_W-1:0] DEPTH_CMP = CMP_W'(DEPTH);

   generate
      if (DEPTH < 4 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
         $error("pfc_top: DEPTH must be a power of two, at least 4");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("pfc_top: DATA_W must be positive");
      end
   endgenerate

   frame_evt_e       evt;
   logic             en_q;
   logic             flush;
   logic             replay;
   logic             push;
   logic             pop;
   logic             ovf_try;
   logic             full;
   logic             empty;
   logic             gate_open;
   logic [CNT_W-1:0] count;
   logic [CMP_W-1:0] level;
   logic [CMP_W-1:0] low_x;
   logic [CMP_W-1:0] high_x;
   logic [CMP_W-1:0] pre_x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else begin
         en_q <= ctl_enable;
      end
   end

   // controller toggle outranks the frame event
   always_comb begin
      if (ctl_enable != en_q) begin
         evt = EVT_CTRL;
      end else if (vfp_start && !cfg_self_refresh) begin
         evt = EVT_FRAME;
      end else if (vfp_start) begin
         evt = EVT_REPLAY;
      end else begin
         evt = EVT_NONE;
      end
   end

   assign flush   = (evt == EVT_CTRL) || (evt == EVT_FRAME);
   assign replay  = (evt == EVT_REPLAY);
   assign push    = wr_en && !full && (evt == EVT_NONE);
   assign pop     = pix_valid && pix_ready && (evt == EVT_NONE);
   assign ovf_try = wr_en && full;

   assign low_x  = CMP_W'(cfg_low);
   assign high_x = CMP_W'(cfg_high);
   assign pre_x  = CMP_W'(cfg_preload);
   assign level  = cfg_preload_sel ? high_x : pre_x;

   assign cfg_err = (low_x >= high_x) || (high_x > DEPTH_CMP) ||
                    (!cfg_preload_sel && ((pre_x < low_x) || (pre_x > high_x)));

   assign wr_ready  = !full;
   assign pix_valid = gate_open && !empty;

   pfc_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .pop    (pop),
      .flush  (flush),
      .replay (replay),
      .wdata  (wr_data),
      .rdata  (pix_data),
      .count  (count),
      .full   (full),
      .empty  (empty)
   );

   pfc_watermark #(
      .CNT_W (CNT_W)
   ) u_wmark (
      .clk       (clk),
      .rst_n     (rst_n),
      .allow     (ctl_enable && !cfg_self_refresh && !flush),
      .count     (count),
      .low_mark  (cfg_low),
      .high_mark (cfg_high),
      .req       (fetch_req)
   );

   pfc_gate #(
      .CMP_W (CMP_W)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .replay     (replay),
      .ovf_try    (ovf_try),
      .occ        (CMP_W'(count)),
      .level      (level),
      .enabled    (ctl_enable),
      .vid_active (vid_active),
      .pix_ready  (pix_ready),
      .empty      (empty),
      .uf_clr     (uf_clr),
      .gate_open  (gate_open),
      .underflow  (underflow)
   );

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
   parameter int DEPTH = 256,
   parameter int CNT_W = 9
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             ctl_enable,
   input logic             cfg_self_refresh,
   input logic             vid_active,
   input logic             pix_ready,
   input logic             fetch_req,
   input logic             pix_valid,
   input logic             underflow,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cfg_low,
   input logic [CNT_W-1:0] cfg_high
);

   // R1
   req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_req) |-> $past(count <= cfg_low));

   // R1
   req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fetch_req) |-> ($past(count >= cfg_high) || $past(flush) ||
                            $past(!ctl_enable) || $past(cfg_self_refresh)));

   // R2
   sr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_self_refresh || !ctl_enable) |=> !fetch_req);

   // R5
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ((count == '0) && !pix_valid));

   // R3
   valid_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> (count != '0));

   // R9
   uf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underflow) |-> ($past(pix_ready) && $past(vid_active)));

   // R10
   occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

endmodule

bind pfc_top pfc_checker #(
   .DEPTH (DEPTH),
   .CNT_W (CNT_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .flush            (flush),
   .ctl_enable       (ctl_enable),
   .cfg_self_refresh (cfg_self_refresh),
   .vid_active       (vid_active),
   .pix_ready        (pix_ready),
   .fetch_req        (fetch_req),
   .pix_valid        (pix_valid),
   .underflow        (underflow),
   .count            (count),
   .cfg_low          (cfg_low),
   .cfg_high         (cfg_high)
);

// File: tb/pfc_top_test.sv
`timescale 1ns/1ps
module pfc_top_test;

   localparam int DW = 16;
   localparam int DP = 16;
   localparam int CW = $clog2(DP + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_enable = 1'b0;
   logic          vfp_start = 1'b0;
   logic          vid_active = 1'b0;
   logic [CW-1:0] cfg_low = CW'(4);
   logic [CW-1:0] cfg_high = CW'(12);
   logic [11:0]   cfg_preload = 12'd8;
   logic          cfg_preload_sel = 1'b0;
   logic          cfg_self_refresh = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_ready;
   logic          fetch_req;
   logic          pix_valid;
   logic          pix_ready = 1'b0;
   logic [DW-1:0] pix_data;
   logic          uf_clr = 1'b0;
   logic          underflow;
   logic          cfg_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] exp_q[$];

   always #2 clk = ~clk;

   pfc_top #(.DATA_W(DW), .DEPTH(DP)) uut (
      .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .vfp_start(vfp_start),
      .vid_active(vid_active), .cfg_low(cfg_low), .cfg_high(cfg_high),
      .cfg_preload(cfg_preload), .cfg_preload_sel(cfg_preload_sel),
      .cfg_self_refresh(cfg_self_refresh), .wr_en(wr_en), .wr_data(wr_data),
      .wr_ready(wr_ready), .fetch_req(fetch_req), .pix_valid(pix_valid),
      .pix_ready(pix_ready), .pix_data(pix_data), .uf_clr(uf_clr),
      .underflow(underflow), .cfg_err(cfg_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: every handshake must match the oldest expected word (R10, R7)
   always @(negedge clk) begin
      if (rst_n && pix_valid && pix_ready) begin
         if (exp_q.size() == 0) begin
            check("R10 unexpected pixel", 32'(pix_data), 32'hFFFF_FFFF);
         end else begin
            check("R10 pixel order", 32'(pix_data), 32'(exp_q[0]));
            void'(exp_q.pop_front());
         end
      end
   end

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_burst(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         wr_en   = 1'b1;
         wr_data = DW'(base + i);
         if (wr_ready) exp_q.push_back(DW'(base + i));
      end
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic drain(input int n);
      @(posedge clk); #1;
      pix_ready = 1'b1;
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
      pix_ready = 1'b0;
   endtask

   task automatic vfp_pulse(input logic with_write);
      @(posedge clk); #1;
      vfp_start = 1'b1;
      wr_en     = with_write;
      wr_data   = DW'(16'hDEAD);
      @(posedge clk); #1;
      vfp_start = 1'b0;
      wr_en     = 1'b0;
      if (!cfg_self_refresh) exp_q.delete();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      // R11 reset state
      check("R11 fetch_req", 32'(fetch_req), 0);
      check("R11 pix_valid", 32'(pix_valid), 0);
      check("R11 underflow", 32'(underflow), 0);
      check("R11 wr_ready", 32'(wr_ready), 1);
      check("R8 legal config", 32'(cfg_err), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      tick(2);
      check("R2 disabled no request", 32'(fetch_req), 0);

      @(posedge clk); #1;
      ctl_enable = 1'b1;             // R6 toggle flush, then request
      tick(3);
      check("R1 request at empty", 32'(fetch_req), 1);

      wr_burst(7, 16'h100);
      tick(2);
      check("R3 gate closed below preload", 32'(pix_valid), 0);
      check("R1 request held mid-range", 32'(fetch_req), 1);
      wr_burst(1, 16'h107);
      tick(2);
      check("R3 gate opens at preload", 32'(pix_valid), 1);
      wr_burst(4, 16'h108);
      tick(2);
      check("R1 request drops at high mark", 32'(fetch_req), 0);
      drain(7);
      tick(2);
      check("R1 hysteresis holds low at 5", 32'(fetch_req), 0);
      drain(1);
      tick(2);
      check("R1 request returns at low mark", 32'(fetch_req), 1);

      vid_active = 1'b1;
      drain(6);
      tick(1);
      check("R9 underflow set", 32'(underflow), 1);
      check("R10 scoreboard empty", 32'(exp_q.size()), 0);
      @(posedge clk); #1; uf_clr = 1'b1;
      @(posedge clk); #1; uf_clr = 1'b0;
      tick(1);
      check("R9 underflow cleared", 32'(underflow), 0);
      vid_active = 1'b0;

      // R5 frame flush with a write in the flush cycle
      wr_burst(5, 16'h200);
      vfp_pulse(1'b1);
      tick(1);
      check("R5 empty after flush", 32'(pix_valid), 0);
      wr_burst(3, 16'h300);
      tick(2);
      check("R5 gate re-armed", 32'(pix_valid), 0);
      wr_burst(5, 16'h303);
      tick(2);
      drain(8);
      tick(1);
      check("R5 dropped write absent", 32'(exp_q.size()), 0);
      drain(2);
      tick(1);
      check("R9 no underflow outside active video", 32'(underflow), 0);

      // R3 preload from high mark
      vfp_pulse(1'b0);
      cfg_preload_sel = 1'b1;
      wr_burst(11, 16'h400);
      tick(2);
      check("R3 high-mark level not reached", 32'(pix_valid), 0);
      wr_burst(1, 16'h40B);
      tick(2);
      check("R3 high-mark level reached", 32'(pix_valid), 1);
      drain(12);
      cfg_preload_sel = 1'b0;

      // R8 config errors
      cfg_preload = 12'd3;
      tick(1);
      check("R8 preload below low", 32'(cfg_err), 1);
      cfg_low = CW'(12);
      cfg_preload = 12'd12;
      tick(1);
      check("R8 low not below high", 32'(cfg_err), 1);
      cfg_low = CW'(4);
      cfg_preload = 12'd200;
      tick(1);
      check("R8 preload above high", 32'(cfg_err), 1);

      // R4 overflow releases the gate
      vfp_pulse(1'b0);
      wr_burst(16, 16'h500);
      tick(2);
      check("R10 full drops ready", 32'(wr_ready), 0);
      check("R4 gate shut before overflow", 32'(pix_valid), 0);
      wr_burst(1, 16'h600);
      tick(2);
      check("R4 gate opened by overflow", 32'(pix_valid), 1);
      drain(16);
      tick(1);
      check("R4 overflow word dropped", 32'(exp_q.size()), 0);
      cfg_preload = 12'd8;

      // R7 self-refresh replay
      vfp_pulse(1'b0);
      wr_burst(10, 16'h700);
      tick(2);
      drain(10);
      cfg_self_refresh = 1'b1;
      tick(2);
      check("R2 no request in self-refresh", 32'(fetch_req), 0);
      for (int i = 0; i < 10; i++) exp_q.push_back(DW'(16'h700 + i));
      vfp_pulse(1'b0);
      tick(1);
      check("R7 replay valid", 32'(pix_valid), 1);
      drain(10);
      tick(1);
      check("R7 replay complete", 32'(exp_q.size()), 0);

      // R6 disable flushes even in self-refresh
      vfp_pulse(1'b0);
      tick(1);
      check("R7 second replay valid", 32'(pix_valid), 1);
      @(posedge clk); #1;
      ctl_enable = 1'b0;
      exp_q.delete();
      tick(2);
      check("R6 disable flushes", 32'(pix_valid), 0);
      check("R2 disabled request low", 32'(fetch_req), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule